// File: doc/BRIEF.md
# Real-time counter with alarm, periodic compare and rollover

This peripheral keeps a free-running up-counter that software reaches through a small word-addressed register bus. The counter advances on a divided tick. The tick starts from one of two source tick inputs, a slow one and a fast one, and then passes through an optional coarse divide stage and an optional fine divide stage. The two stages can be switched on one at a time or together, in which case they cascade.

Three events come out of the counter. An alarm fires when the counter reaches a programmed value. A periodic event fires every N divided ticks. A rollover event fires when the counter wraps from all ones to zero. Each event latches a status flag that software clears by writing a 1 to it. A single interrupt line carries every enabled flag. Writing a new alarm value starts a short synchronisation window, and alarm compares are held off until that window ends.

The oscillators are outside the block. Each source arrives as a one-cycle qualifying pulse in the bus clock domain.

Top module: `rtc_cmp`

## Requirements
- R1: After reset, the control register (byte offset 0x4), the status register (0x8), the counter (0xC), the periodic value (0x10) and the alarm value (0x14) all read 0, `irq` is low, and the supervisor register (0x0) reads 0x80000000. Its bit 31 is the only stored bit.
- R2: Control bits 13:12 pick the source. Code 0 counts `slow_tick` pulses and code 2 counts `fast_tick` pulses. Codes 1 and 3 count nothing.
- R3: Control bit 11 turns on a divide-by-2^DIVA_LOG2 stage and bit 10 turns on a divide-by-2^DIVB_LOG2 stage. Each stage works alone, and with both set the counter advances once per 2^(DIVA_LOG2+DIVB_LOG2) source pulses.
- R4: Control bit 31 enables counting. The counter reads 0 once enable goes from 0 to 1, holds its value while enable is clear, and ignores writes to offset 0xC.
- R5: When the counter wraps from all ones to 0, status bit 10 (rollover) is set.
- R6: Status bit 29 (alarm) is set on the tick that brings the counter to the alarm value. An alarm value of 0 never matches. A write of 1, 2 or 3 to offset 0x14 is stored and read back as 4.
- R7: A write to offset 0x14 raises status bit 18 (alarm busy) for SYNC_TICKS divided ticks. While that bit is high, no alarm match is taken.
- R8: With control bit 15 set and a periodic value P that is not 0, status bit 13 is set on every P-th divided tick.
- R9: Status bits 29, 13 and 10 are cleared by writing 1 to them, and writing back the value read clears exactly those flags. An event in the same cycle as its clear leaves the flag set.
- R10: `irq` is the OR of: alarm flag AND control bit 30; periodic flag AND control bit 14; rollover flag AND control bit 28 AND control bit 30.
- R11: While the counter is enabled, writes to control bits 13:10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle pulse from the slow source |
| fast_tick | input | 1 | One-cycle pulse from the fast source |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of functions can fall in the same cycle. A status write that clears the periodic flag can coincide with the tick that sets it again. The bench provokes this by setting the periodic value to 1 and driving the clear and a source pulse in one cycle, and it expects the flag to stay set. A clear with no pulse must then drop it. In the other pair, an alarm write lands one step before a match would occur. The bench expects the busy window to hide that match.

// File: rtl/rtcc_pkg.sv
// Package: register offsets, bit positions and shared types of the
// real-time counter. Assumes a byte-addressed bus with word registers.
package rtcc_pkg;
    localparam int OFS_SUPV = 'h00;
    localparam int OFS_CTRL = 'h04;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_CNT  = 'h0C;
    localparam int OFS_PER  = 'h10;
    localparam int OFS_ALRM = 'h14;

    // control bit positions
    localparam int B_EN      = 31;
    localparam int B_ALRM_IE = 30;
    localparam int B_ROLL_IE = 28;
    localparam int B_PER_EN  = 15;
    localparam int B_PER_IE  = 14;
    localparam int B_SEL_HI  = 13;
    localparam int B_SEL_LO  = 12;
    localparam int B_DIVA    = 11;
    localparam int B_DIVB    = 10;

    // status bit positions
    localparam int B_ALRM_F = 29;
    localparam int B_BUSY   = 18;
    localparam int B_PER_F  = 13;
    localparam int B_ROLL_F = 10;

    localparam logic [1:0] SEL_SLOW = 2'd0;
    localparam logic [1:0] SEL_FAST = 2'd2;

    localparam int ALARM_MIN = 4;

    typedef struct packed {
        logic       en;
        logic       alrm_ie;
        logic       roll_ie;
        logic       per_en;
        logic       per_ie;
        logic [1:0] sel;
        logic       div_a;
        logic       div_b;
    } ctrl_t;
endpackage

// File: rtl/rtcc_div_stage.sv
// One power-of-two divide stage. When it is bypassed, the tick passes
// straight through. Assumes LOG2 >= 1 and tick_in is a one-cycle pulse.
module rtcc_div_stage #(
    parameter int LOG2 = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic div_en,
    input  logic tick_in,
    output logic tick_out
);
    logic [LOG2-1:0] cnt_q;

    // count input ticks; restart when cleared or bypassed
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !div_en)
            cnt_q <= '0;
        else if (tick_in)
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick_out = div_en ? (tick_in & (&cnt_q)) : tick_in;
endmodule

// File: rtl/rtcc_prescaler.sv
// Source select followed by two cascadable divide stages. The stages are
// held cleared while the counter is disabled. Assumes the source inputs
// are one-cycle pulses synchronous to clk.
module rtcc_prescaler #(
    parameter int DIVA_LOG2 = 9,
    parameter int DIVB_LOG2 = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [1:0] sel,
    input  logic       div_a,
    input  logic       div_b,
    input  logic       slow_tick,
    input  logic       fast_tick,
    output logic       tick
);
    import rtcc_pkg::*;

    logic src_tick;
    logic mid_tick;

    // pick the source pulse; unused codes give no pulse
    always_comb begin
        case (sel)
            SEL_SLOW: src_tick = slow_tick;
            SEL_FAST: src_tick = fast_tick;
            default:  src_tick = 1'b0;
        endcase
    end

    rtcc_div_stage #(.LOG2(DIVA_LOG2)) u_stage_a (
        .clk(clk), .rst_n(rst_n), .clr(clr), .div_en(div_a),
        .tick_in(src_tick), .tick_out(mid_tick)
    );

    rtcc_div_stage #(.LOG2(DIVB_LOG2)) u_stage_b (
        .clk(clk), .rst_n(rst_n), .clr(clr), .div_en(div_b),
        .tick_in(mid_tick), .tick_out(tick)
    );
endmodule

// File: rtl/rtcc_core.sv
// Counter core: the main counter, the alarm compare with its sync window,
// the periodic compare and the rollover event. The events are one-cycle
// pulses. Assumes tick is already divided and gated by the source select.
module rtcc_core #(
    parameter int CNT_W      = 32,
    parameter int SYNC_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             tick,
    input  logic             per_en,
    input  logic [CNT_W-1:0] per_val,
    input  logic [CNT_W-1:0] alrm_val,
    input  logic             alrm_wr,
    output logic [CNT_W-1:0] count,
    output logic             roll_evt,
    output logic             alrm_evt,
    output logic             per_evt,
    output logic             sync_busy
);
    localparam int SW = $clog2(SYNC_TICKS + 1);

    logic             en_q;
    logic             start;
    logic             adv;
    logic [SW-1:0]    sync_q;
    logic [CNT_W-1:0] per_cnt_q;
    logic [CNT_W-1:0] nxt;

    assign start     = cnt_en & ~en_q;
    assign adv       = tick & cnt_en & ~start;
    assign nxt       = count + 1'b1;
    assign sync_busy = (sync_q != '0);
    assign roll_evt  = adv & (&count);
    assign alrm_evt  = adv & ~sync_busy & (alrm_val != '0) & (nxt == alrm_val);
    assign per_evt   = adv & per_en & (per_val != '0) & ((per_cnt_q + 1'b1) == per_val);

    // remember enable to find its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= cnt_en;
    end

    // main counter: zero on enable rise, step on each divided tick
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (start) count <= '0;
        else if (adv)   count <= nxt;
    end

    // alarm sync window, counted in divided ticks
    always_ff @(posedge clk) begin
        if (!rst_n)                 sync_q <= '0;
        else if (alrm_wr)           sync_q <= SW'(SYNC_TICKS);
        else if (adv && sync_busy)  sync_q <= sync_q - 1'b1;
    end

    // periodic compare counter, restarts after each hit
    always_ff @(posedge clk) begin
        if (!rst_n || !per_en || start) per_cnt_q <= '0;
        else if (per_evt)               per_cnt_q <= '0;
        else if (adv)                   per_cnt_q <= per_cnt_q + 1'b1;
    end
endmodule

// File: rtl/rtc_cmp.sv
// Top of the real-time counter: register file, status flags with
// write-1-to-clear, and the combined interrupt. Assumes CNT_W <= 32 and
// that every register sits at a word-aligned byte offset.
module rtc_cmp #(
    parameter int CNT_W      = 32,
    parameter int DIVA_LOG2  = 9,
    parameter int DIVB_LOG2  = 5,
    parameter int SYNC_TICKS = 2,
    parameter int ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              fast_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    import rtcc_pkg::*;

    ctrl_t            ctrl_q;
    logic             supv_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] alrm_q;
    logic [CNT_W-1:0] wval;
    logic             alrm_f_q, per_f_q, roll_f_q;
    logic             wr_supv, wr_ctrl, wr_stat, wr_per, wr_alrm;
    logic             tick;
    logic [CNT_W-1:0] count;
    logic             roll_evt, alrm_evt, per_evt, sync_busy;
    logic [3:0]       clk_cfg;

    assign wr_supv = bus_wr && (bus_addr == ADDR_W'(OFS_SUPV));
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign wr_per  = bus_wr && (bus_addr == ADDR_W'(OFS_PER));
    assign wr_alrm = bus_wr && (bus_addr == ADDR_W'(OFS_ALRM));
    assign wval    = bus_wdata[CNT_W-1:0];
    assign clk_cfg = {ctrl_q.sel, ctrl_q.div_a, ctrl_q.div_b};

    // supervisor register: one stored bit
    always_ff @(posedge clk) begin
        if (!rst_n)       supv_q <= 1'b1;
        else if (wr_supv) supv_q <= bus_wdata[31];
    end

    // control register; clock settings locked while counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.en      <= bus_wdata[B_EN];
            ctrl_q.alrm_ie <= bus_wdata[B_ALRM_IE];
            ctrl_q.roll_ie <= bus_wdata[B_ROLL_IE];
            ctrl_q.per_en  <= bus_wdata[B_PER_EN];
            ctrl_q.per_ie  <= bus_wdata[B_PER_IE];
            if (!ctrl_q.en) begin
                ctrl_q.sel   <= bus_wdata[B_SEL_HI:B_SEL_LO];
                ctrl_q.div_a <= bus_wdata[B_DIVA];
                ctrl_q.div_b <= bus_wdata[B_DIVB];
            end
        end
    end

    // periodic value register
    always_ff @(posedge clk) begin
        if (!rst_n)      per_q <= '0;
        else if (wr_per) per_q <= wval;
    end

    // alarm value register; small non-zero values raised to the minimum
    always_ff @(posedge clk) begin
        if (!rst_n)
            alrm_q <= '0;
        else if (wr_alrm) begin
            if (wval != '0 && wval < CNT_W'(ALARM_MIN))
                alrm_q <= CNT_W'(ALARM_MIN);
            else
                alrm_q <= wval;
        end
    end

    // status flags: an event wins over a write-1 clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alrm_f_q <= 1'b0;
            per_f_q  <= 1'b0;
            roll_f_q <= 1'b0;
        end else begin
            alrm_f_q <= alrm_evt | (alrm_f_q & ~(wr_stat & bus_wdata[B_ALRM_F]));
            per_f_q  <= per_evt  | (per_f_q  & ~(wr_stat & bus_wdata[B_PER_F]));
            roll_f_q <= roll_evt | (roll_f_q & ~(wr_stat & bus_wdata[B_ROLL_F]));
        end
    end

    rtcc_prescaler #(.DIVA_LOG2(DIVA_LOG2), .DIVB_LOG2(DIVB_LOG2)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr(~ctrl_q.en), .sel(ctrl_q.sel),
        .div_a(ctrl_q.div_a), .div_b(ctrl_q.div_b),
        .slow_tick(slow_tick), .fast_tick(fast_tick), .tick(tick)
    );

    rtcc_core #(.CNT_W(CNT_W), .SYNC_TICKS(SYNC_TICKS)) u_core (
        .clk(clk), .rst_n(rst_n), .cnt_en(ctrl_q.en), .tick(tick),
        .per_en(ctrl_q.per_en), .per_val(per_q), .alrm_val(alrm_q),
        .alrm_wr(wr_alrm), .count(count), .roll_evt(roll_evt),
        .alrm_evt(alrm_evt), .per_evt(per_evt), .sync_busy(sync_busy)
    );

    // combined interrupt; rollover also needs the alarm enable
    assign irq = (alrm_f_q & ctrl_q.alrm_ie)
               | (per_f_q  & ctrl_q.per_ie)
               | (roll_f_q & ctrl_q.roll_ie & ctrl_q.alrm_ie);

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_SUPV): bus_rdata[31] = supv_q;
            ADDR_W'(OFS_CTRL): begin
                bus_rdata[B_EN]            = ctrl_q.en;
                bus_rdata[B_ALRM_IE]       = ctrl_q.alrm_ie;
                bus_rdata[B_ROLL_IE]       = ctrl_q.roll_ie;
                bus_rdata[B_PER_EN]        = ctrl_q.per_en;
                bus_rdata[B_PER_IE]        = ctrl_q.per_ie;
                bus_rdata[B_SEL_HI:B_SEL_LO] = ctrl_q.sel;
                bus_rdata[B_DIVA]          = ctrl_q.div_a;
                bus_rdata[B_DIVB]          = ctrl_q.div_b;
            end
            ADDR_W'(OFS_STAT): begin
                bus_rdata[B_ALRM_F] = alrm_f_q;
                bus_rdata[B_BUSY]   = sync_busy;
                bus_rdata[B_PER_F]  = per_f_q;
                bus_rdata[B_ROLL_F] = roll_f_q;
            end
            ADDR_W'(OFS_CNT):  bus_rdata[CNT_W-1:0] = count;
            ADDR_W'(OFS_PER):  bus_rdata[CNT_W-1:0] = per_q;
            ADDR_W'(OFS_ALRM): bus_rdata[CNT_W-1:0] = alrm_q;
            default:           bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_cmp_chk.sv
// Checker for rtc_cmp, attached with bind. Relates the counter, the
// alarm sync window, the clock settings and the interrupt over time.
module rtc_cmp_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic [CNT_W-1:0] count,
    input logic             irq,
    input logic             alrm_ie,
    input logic             per_ie,
    input logic             alrm_wr,
    input logic             sync_busy,
    input logic [CNT_W-1:0] alrm_val,
    input logic [3:0]       clk_cfg
);
    // R4: disabled counter holds its value
    p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count));

    // R4: counter only holds, steps by one, or returns to zero
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + 1'b1) || (count == '0));

    // R7: an alarm write opens the busy window
    p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alrm_wr |=> sync_busy);

    // R6: stored alarm is zero or at least the minimum
    p_alarm_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alrm_val == '0) || (alrm_val >= CNT_W'(4)));

    // R10: with both interrupt enables clear, no interrupt
    p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!alrm_ie && !per_ie) |-> !irq);

    // R11: clock settings do not move while counting
    p_cfg_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_en) |-> $stable(clk_cfg));
endmodule

bind rtc_cmp rtc_cmp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_en(ctrl_q.en), .count(count), .irq(irq),
    .alrm_ie(ctrl_q.alrm_ie), .per_ie(ctrl_q.per_ie), .alrm_wr(wr_alrm),
    .sync_busy(sync_busy), .alrm_val(alrm_q), .clk_cfg(clk_cfg)
);

// File: tb/rtc_cmp_bench.sv
// Bench: small configuration (8-bit counter, divide-by-4 and divide-by-2
// stages) so that wraps and every divider setting can be swept quickly.
module rtc_cmp_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int DA = 2;
    localparam int DB = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0, fast_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_chk = 0, n_fail = 0;

    localparam logic [31:0] EN = 32'h8000_0000, AIE = 32'h4000_0000,
        RIE = 32'h1000_0000, PEN = 32'h0000_8000, PIE = 32'h0000_4000;

    rtc_cmp #(.CNT_W(CW), .DIVA_LOG2(DA), .DIVB_LOG2(DB), .SYNC_TICKS(2)) u_rtc_cmp (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic pulse(input bit fast, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fast) fast_tick = 1'b1; else slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0; fast_tick = 1'b0;
        end
    endtask

    // restart the counter from zero with a given control word
    task automatic restart(input logic [31:0] c);
        wr(5'h04, 32'h0);
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h04, c);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h04, d); check("R1 ctrl", d, 0);
        rd(5'h08, d); check("R1 status", d, 0);
        rd(5'h0C, d); check("R1 counter", d, 0);
        rd(5'h10, d); check("R1 periodic", d, 0);
        rd(5'h14, d); check("R1 alarm", d, 0);
        rd(5'h00, d); check("R1 supv", d, 32'h8000_0000);
        check("R1 irq", {31'b0, irq}, 0);

        // R2/R3 sweep of sources and divider settings
        for (int sel = 0; sel < 4; sel++) begin
            for (int cfg = 0; cfg < 4; cfg++) begin
                int dv, exp_n;
                logic [31:0] c;
                dv = ((cfg & 2) != 0 ? (1 << DA) : 1) * ((cfg & 1) != 0 ? (1 << DB) : 1);
                c = EN | (32'(sel) << 12) | (32'(cfg) << 10);
                restart(c);
                pulse(sel == 2, 21);
                pulse(sel != 2, 3);
                exp_n = (sel == 0 || sel == 2) ? (21 / dv) : 0;
                rd(5'h0C, d);
                check($sformatf("R3 R2 sel%0d div%0d", sel, cfg), d, 32'(exp_n));
            end
        end

        // R11 clock settings locked while enabled
        restart(EN);
        wr(5'h04, EN | 32'h0000_3C00);
        rd(5'h04, d); check("R11 cfg lock", d, EN);

        // R4 hold while disabled, read-only counter, zero on enable
        pulse(0, 5);
        wr(5'h0C, 32'h55);
        rd(5'h0C, d); check("R4 read-only", d, 5);
        wr(5'h04, 32'h0);
        pulse(0, 4);
        rd(5'h0C, d); check("R4 hold", d, 5);
        wr(5'h04, EN);
        repeat (3) @(negedge clk);
        rd(5'h0C, d); check("R4 zero on enable", d, 0);

        // R5 rollover, R10 shared enable
        restart(EN | RIE);
        pulse(0, 255);
        rd(5'h08, d); check("R5 no roll yet", d & 32'h400, 0);
        pulse(0, 1);
        rd(5'h0C, d); check("R5 wrap to zero", d, 0);
        rd(5'h08, d); check("R5 roll flag", d & 32'h400, 32'h400);
        check("R10 roll masked by alarm ie", {31'b0, irq}, 0);
        wr(5'h04, EN | RIE | AIE);
        @(negedge clk); check("R10 roll irq", {31'b0, irq}, 1);

        // R6/R7 alarm with sync window
        restart(EN | AIE);
        wr(5'h14, 10);
        rd(5'h08, d); check("R7 busy set", d & 32'h4_0000, 32'h4_0000);
        pulse(0, 2);
        rd(5'h08, d); check("R7 busy clear", d & 32'h4_0000, 0);
        pulse(0, 7);
        rd(5'h08, d); check("R6 before match", d & 32'h2000_0000, 0);
        pulse(0, 1);
        rd(5'h08, d); check("R6 match", d & 32'h2000_0000, 32'h2000_0000);
        check("R10 alarm irq", {31'b0, irq}, 1);
        wr(5'h14, 2);
        rd(5'h14, d); check("R6 min value", d, 4);
        wr(5'h14, 0);
        rd(5'h14, d); check("R6 disarm", d, 0);
        wr(5'h08, 32'hFFFF_FFFF);
        pulse(0, 2);
        rd(5'h0C, d);
        wr(5'h14, d + 1);
        pulse(0, 1);
        rd(5'h08, d); check("R7 suppressed match", d & 32'h2000_0000, 0);

        // R8 periodic, R9 write-back clear
        restart(EN | PEN | PIE);
        wr(5'h10, 3);
        pulse(0, 3);
        rd(5'h08, s); check("R8 first period", s, 32'h2000);
        check("R10 periodic irq", {31'b0, irq}, 1);
        wr(5'h08, s);
        rd(5'h08, d); check("R9 write-back clear", d, 0);
        pulse(0, 2);
        rd(5'h08, d); check("R8 mid period", d, 0);
        pulse(0, 1);
        rd(5'h08, d); check("R8 second period", d, 32'h2000);

        // R9 event in the same cycle as its clear
        wr(5'h10, 1);
        pulse(0, 1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 32'h2000; slow_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; slow_tick = 1'b0;
        rd(5'h08, d); check("R9 event beats clear", d, 32'h2000);
        wr(5'h08, 32'h2000);
        rd(5'h08, d); check("R9 plain clear", d, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule